// File: doc/BRIEF.md
# SPI Flash Program and Erase Sequencer

This block sits on the host side of a serial NOR flash and turns one request into the full series of SPI transactions that a write needs. A request names one of four operations: page program, subsector erase, sector erase or whole-device erase. It also carries a 24-bit start address and, for programs, a byte count. Data bytes for a program arrive on a separate valid/ready stream.

For every command the sequencer first opens a one-byte write-enable transaction. It then sends the command itself. After that it reads the status register again and again until the busy flag clears. A program request that runs past the end of a 256-byte page is cut into several page-sized pieces. Each piece gets its own write enable, command and polling phase. If the device stays busy for a set number of status reads, the request ends with an error.

Chip select goes high between every pair of transactions. The serial clock is the system clock divided down by a parameter. The wire protocol is SPI mode 0, most significant bit first.

Top module: `flash_prog_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `spi_cs_n` is 1, `spi_sclk` is 0, `req_ready` is 1, and `done` and `err` are 0.
- R2: Serial timing follows SPI mode 0, with these rules:
  - `spi_sclk` idles low and pulses only while `spi_cs_n` is low.
  - Within a byte, rising edges are 2*CLK_DIV system cycles apart.
  - `spi_mosi` carries each byte most significant bit first, stable at each rising edge.
  - `spi_miso` is sampled on the rising edge.
- R3: Every program or erase command transaction is preceded by its own transaction that holds only the byte 0x06.
- R4: The operation code selects the command frame:
  - op 0 (program): 0x02, then three address bytes high byte first, then the data bytes.
  - op 1 (subsector erase): 0x20, then three address bytes.
  - op 2 (sector erase): 0xD8, then three address bytes.
  - op 3 (whole-device erase): the single byte 0xC7, with no address.
- R5: Page splitting works as follows:
  - No program transaction crosses a 256-byte page boundary.
  - Each piece holds min(remaining, 256 - address[7:0]) bytes.
  - The next piece starts at the following address, with the 24-bit address wrapping.
- R6: After each command transaction, a two-byte transaction 0x05, 0x00 reads status. The read repeats while bit 0 of the returned status byte is 1. Every other status bit is ignored.
- R7: Between any two transactions `spi_cs_n` stays high for at least GAP_CYC system cycles.
- R8: If MAX_POLLS status reads in a row report busy, `err` and `done` pulse together. No further transaction follows.
- R9: Request handshake and completion:
  - `done` pulses for one cycle after the final status read reports not busy.
  - `req_ready` is 1 only while idle.
  - No request is taken between acceptance and `done`.
- R10: Data stream handshake:
  - A data byte is taken only when `wr_valid` and `wr_ready` are both 1.
  - `wr_ready` is 1 only inside a program transaction.
  - Stalls on `wr_valid` do not change the bytes sent.
- R11: A program request with a byte count of 0 pulses `done` in the following cycle with no SPI transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken this cycle if valid |
| req_op | input | 2 | 0 program, 1 subsector erase, 2 sector erase, 3 whole-device erase |
| req_addr | input | 24 | Start address |
| req_len | input | LEN_W | Program byte count (ignored for erases) |
| wr_valid | input | 1 | Data byte offered |
| wr_ready | output | 1 | Data byte taken this cycle if valid |
| wr_data | input | 8 | Program data byte |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Polling limit hit, pulses with done |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench runs a behavioural flash model that decodes every transaction and answers status reads with a chosen number of busy replies. It compares the full byte stream against an expected list built from the requirements.

Program requests cover three cases:
- Aligned full pages, which must not split.
- Unaligned starts that cross one boundary, which test the piece length.
- A start near the top of the address space, which tests address wrap.

Stalled and unstalled data streams show that the handshake alone paces the data. Each erase kind is run once, with and without busy replies, which tells the frame shapes apart. A device that never goes idle and a zero-length program cover the two early-exit paths.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int PAGE_BYTES = 256;
    localparam int ADDR_W     = 24;

    typedef enum logic [1:0] {
        OP_PROG       = 2'd0,
        OP_SUB_ERASE  = 2'd1,
        OP_SEC_ERASE  = 2'd2,
        OP_CHIP_ERASE = 2'd3
    } flash_op_e;

    localparam logic [7:0] CMD_WREN = 8'h06;
    localparam logic [7:0] CMD_PROG = 8'h02;
    localparam logic [7:0] CMD_SUB  = 8'h20;
    localparam logic [7:0] CMD_SEC  = 8'hD8;
    localparam logic [7:0] CMD_CHIP = 8'hC7;
    localparam logic [7:0] CMD_RDSR = 8'h05;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WREN,
        ST_CMD,
        ST_ADDR,
        ST_DATA,
        ST_RDSR,
        ST_STAT,
        ST_GAP
    } seq_state_e;

    function automatic logic [7:0] op_command(flash_op_e op);
        case (op)
            OP_PROG:      return CMD_PROG;
            OP_SUB_ERASE: return CMD_SUB;
            OP_SEC_ERASE: return CMD_SEC;
            default:      return CMD_CHIP;
        endcase
    endfunction

    // Bytes that fit in the current page, capped by what is left.
    function automatic int unsigned page_chunk(int unsigned offs, int unsigned remain);
        int unsigned room;
        room = PAGE_BYTES - offs;
        return (remain < room) ? remain : room;
    endfunction

endpackage

// File: rtl/fs_spi_shifter.sv
module fs_spi_shifter #(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       busy,
    output logic       done,
    output logic       rx_bit0,
    output logic       sclk,
    output logic       mosi
);
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);

    logic [7:0]    sh_q;
    logic [DW-1:0] div_q;
    logic [2:0]    bit_q;
    logic          busy_q, sclk_q, done_q, rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            div_q  <= '0;
            bit_q  <= '0;
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
            rx_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                busy_q <= 1'b1;
                sh_q   <= tx;
                div_q  <= '0;
                bit_q  <= '0;
                sclk_q <= 1'b0;
            end else if (busy_q) begin
                if (div_q == DIV_LAST) begin
                    div_q <= '0;
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                        rx_q   <= miso;
                    end else begin
                        sclk_q <= 1'b0;
                        if (bit_q == 3'd7) begin
                            busy_q <= 1'b0;
                            done_q <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 3'd1;
                            sh_q  <= {sh_q[6:0], 1'b0};
                        end
                    end
                end else begin
                    div_q <= div_q + DW'(1);
                end
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign rx_bit0 = rx_q;
    assign sclk    = sclk_q;
    assign mosi    = sh_q[7];

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !sclk_q); // R2
    AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy_q); // R2

endmodule

// File: rtl/fs_page_tracker.sv
module fs_page_tracker
    import flash_seq_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [LEN_W-1:0]  len_in,
    input  logic              chunk_load,
    input  logic              take,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              remain_zero,
    output logic              chunk_zero
);
    localparam int CW  = $clog2(PAGE_BYTES + 1);
    localparam int POW = $clog2(PAGE_BYTES);

    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  remain_q;
    logic [CW-1:0]     chunk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            remain_q <= '0;
            chunk_q  <= '0;
        end else if (load) begin
            addr_q   <= addr_in;
            remain_q <= len_in;
            chunk_q  <= '0;
        end else if (chunk_load) begin
            chunk_q <= CW'(page_chunk(int'(addr_q[POW-1:0]), int'(remain_q)));
        end else if (take) begin
            addr_q   <= addr_q + ADDR_W'(1);
            remain_q <= remain_q - LEN_W'(1);
            chunk_q  <= chunk_q - CW'(1);
        end
    end

    assign cur_addr    = addr_q;
    assign remain_zero = (remain_q == '0);
    assign chunk_zero  = (chunk_q == '0);

    AST_CHUNK_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
        (take && chunk_q > CW'(1)) |-> (addr_q[POW-1:0] != '1)); // R5
    AST_TAKE_HAS_ROOM: assert property (@(posedge clk) disable iff (rst)
        take |-> (!chunk_zero && !remain_zero)); // R5

endmodule

// File: rtl/fs_seq_ctrl.sv
module fs_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int GAP_CYC   = 2,
    parameter int MAX_POLLS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  flash_op_e         req_op,
    input  logic              req_len_zero,
    output logic              req_ready,
    input  logic              wr_valid,
    input  logic [7:0]        wr_data,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              remain_zero,
    input  logic              chunk_zero,
    output logic              trk_load,
    output logic              chunk_load,
    output logic              byte_take,
    input  logic              sh_busy,
    input  logic              sh_done,
    input  logic              sh_wip,
    output logic              sh_start,
    output logic [7:0]        sh_tx,
    output logic              cs_n,
    output logic              done,
    output logic              err
);
    localparam int GW = $clog2(GAP_CYC + 1);
    localparam int PW = $clog2(MAX_POLLS + 1);
    localparam logic [GW-1:0] GAP_LAST  = GW'(GAP_CYC - 1);
    localparam logic [PW-1:0] POLL_LAST = PW'(MAX_POLLS - 1);

    seq_state_e    state_q, next_q;
    flash_op_e     op_q;
    logic          pend_q;
    logic [1:0]    idx_q;
    logic [GW-1:0] gap_q;
    logic [PW-1:0] poll_q;
    logic          done_q, err_q;

    always_comb begin
        sh_start  = 1'b0;
        sh_tx     = 8'h00;
        wr_ready  = 1'b0;
        byte_take = 1'b0;
        case (state_q)
            ST_WREN: begin sh_tx = CMD_WREN;         sh_start = !pend_q; end
            ST_CMD:  begin sh_tx = op_command(op_q); sh_start = !pend_q; end
            ST_ADDR: begin
                case (idx_q)
                    2'd0:    sh_tx = cur_addr[23:16];
                    2'd1:    sh_tx = cur_addr[15:8];
                    default: sh_tx = cur_addr[7:0];
                endcase
                sh_start = !pend_q;
            end
            ST_DATA: begin
                wr_ready  = !pend_q && !chunk_zero;
                sh_tx     = wr_data;
                sh_start  = wr_ready && wr_valid;
                byte_take = sh_start;
            end
            ST_RDSR: begin sh_tx = CMD_RDSR; sh_start = !pend_q; end
            ST_STAT: begin sh_tx = 8'h00;    sh_start = !pend_q; end
            default: ;
        endcase
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign trk_load   = req_valid && req_ready;
    assign chunk_load = (state_q == ST_WREN) && !pend_q;
    assign cs_n       = (state_q == ST_IDLE) || (state_q == ST_GAP);
    assign done       = done_q;
    assign err        = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            next_q  <= ST_IDLE;
            op_q    <= OP_PROG;
            pend_q  <= 1'b0;
            idx_q   <= '0;
            gap_q   <= '0;
            poll_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (sh_start) pend_q <= 1'b1;
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    op_q   <= req_op;
                    poll_q <= '0;
                    if (req_op == OP_PROG && req_len_zero) done_q <= 1'b1;
                    else state_q <= ST_WREN;
                end
                ST_WREN: if (pend_q && sh_done) begin
                    pend_q  <= 1'b0;
                    state_q <= ST_GAP;
                    next_q  <= ST_CMD;
                end
                ST_CMD: if (pend_q && sh_done) begin
                    pend_q <= 1'b0;
                    if (op_q == OP_CHIP_ERASE) begin
                        state_q <= ST_GAP;
                        next_q  <= ST_RDSR;
                    end else begin
                        state_q <= ST_ADDR;
                        idx_q   <= '0;
                    end
                end
                ST_ADDR: if (pend_q && sh_done) begin
                    pend_q <= 1'b0;
                    if (idx_q == 2'd2) begin
                        if (op_q == OP_PROG) state_q <= ST_DATA;
                        else begin
                            state_q <= ST_GAP;
                            next_q  <= ST_RDSR;
                        end
                    end else begin
                        idx_q <= idx_q + 2'd1;
                    end
                end
                ST_DATA: if (pend_q && sh_done) begin
                    pend_q <= 1'b0;
                    if (chunk_zero) begin
                        state_q <= ST_GAP;
                        next_q  <= ST_RDSR;
                    end
                end
                ST_RDSR: if (pend_q && sh_done) begin
                    pend_q  <= 1'b0;
                    state_q <= ST_STAT;
                end
                ST_STAT: if (pend_q && sh_done) begin
                    pend_q <= 1'b0;
                    if (!sh_wip) begin
                        if (op_q == OP_PROG && !remain_zero) begin
                            state_q <= ST_GAP;
                            next_q  <= ST_WREN;
                            poll_q  <= '0;
                        end else begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end
                    end else if (poll_q == POLL_LAST) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        err_q   <= 1'b1;
                    end else begin
                        poll_q  <= poll_q + PW'(1);
                        state_q <= ST_GAP;
                        next_q  <= ST_RDSR;
                    end
                end
                ST_GAP: begin
                    if (gap_q == GAP_LAST) begin
                        gap_q   <= '0;
                        state_q <= next_q;
                    end else begin
                        gap_q <= gap_q + GW'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_NO_SCLK_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sh_busy); // R2
    AST_ERR_HAS_DONE: assert property (@(posedge clk) disable iff (rst)
        err |-> done); // R8
    AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !(req_op == OP_PROG && req_len_zero)) |=> !req_ready); // R9
    AST_DATA_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> !cs_n); // R10
    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (rst)
        poll_q < PW'(MAX_POLLS)); // R8

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import flash_seq_pkg::*;
#(
    parameter int CLK_DIV   = 2,
    parameter int GAP_CYC   = 2,
    parameter int MAX_POLLS = 8,
    parameter int LEN_W     = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             done,
    output logic             err,
    output logic             spi_sclk,
    output logic             spi_cs_n,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    logic              trk_load, chunk_load, byte_take;
    logic [ADDR_W-1:0] cur_addr;
    logic              remain_zero, chunk_zero;
    logic              sh_start, sh_busy, sh_done, sh_wip;
    logic [7:0]        sh_tx;

    fs_page_tracker #(.LEN_W(LEN_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .load       (trk_load),
        .addr_in    (req_addr),
        .len_in     (req_len),
        .chunk_load (chunk_load),
        .take       (byte_take),
        .cur_addr   (cur_addr),
        .remain_zero(remain_zero),
        .chunk_zero (chunk_zero)
    );

    fs_seq_ctrl #(.GAP_CYC(GAP_CYC), .MAX_POLLS(MAX_POLLS)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_op      (flash_op_e'(req_op)),
        .req_len_zero(req_len == '0),
        .req_ready   (req_ready),
        .wr_valid    (wr_valid),
        .wr_data     (wr_data),
        .wr_ready    (wr_ready),
        .cur_addr    (cur_addr),
        .remain_zero (remain_zero),
        .chunk_zero  (chunk_zero),
        .trk_load    (trk_load),
        .chunk_load  (chunk_load),
        .byte_take   (byte_take),
        .sh_busy     (sh_busy),
        .sh_done     (sh_done),
        .sh_wip      (sh_wip),
        .sh_start    (sh_start),
        .sh_tx       (sh_tx),
        .cs_n        (spi_cs_n),
        .done        (done),
        .err         (err)
    );

    fs_spi_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .start  (sh_start),
        .tx     (sh_tx),
        .miso   (spi_miso),
        .busy   (sh_busy),
        .done   (sh_done),
        .rx_bit0(sh_wip),
        .sclk   (spi_sclk),
        .mosi   (spi_mosi)
    );

endmodule

// File: tb/flash_prog_seq_tb.sv
module flash_prog_seq_tb;
    localparam int CLK_DIV   = 2;
    localparam int GAP_CYC   = 2;
    localparam int MAX_POLLS = 8;
    localparam int LEN_W     = 12;
    localparam int PER       = 20;
    localparam int ENDM      = 256;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [1:0]       req_op = 2'd0;
    logic [23:0]      req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic             wr_valid = 1'b0;
    logic             wr_ready;
    logic [7:0]       wr_data = '0;
    logic             done, err;
    logic             spi_sclk, spi_cs_n, spi_mosi;
    logic             spi_miso = 1'b0;

    always #(PER/2) clk = ~clk;

    flash_prog_seq #(.CLK_DIV(CLK_DIV), .GAP_CYC(GAP_CYC), .MAX_POLLS(MAX_POLLS), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .done(done), .err(err), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    int        obs_q[$];
    int        exp_q[$];
    int        cur_bytes[$];
    logic [7:0] sh_in;
    logic [7:0] mo;
    int        bitn = 0;
    int        busy_left = 0;
    int        cfg_busy = 0;
    time       last_rise = 0;
    time       cs_rise_t = 0;
    bit        period_bad = 0;
    int        gap_min = 1000000;

    always @(negedge spi_cs_n) begin
        int g;
        bitn = 0;
        cur_bytes.delete();
        mo = 8'h00;
        spi_miso = 1'b0;
        g = int'(($time - cs_rise_t) / PER);
        if (g < gap_min) gap_min = g;
    end

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            if (bitn != 0 && ($time - last_rise) != time'(2*CLK_DIV*PER)) period_bad = 1;
            last_rise = $time;
            sh_in = {sh_in[6:0], spi_mosi};
            bitn++;
            if (bitn == 8) begin
                bitn = 0;
                cur_bytes.push_back(int'(sh_in));
                if (cur_bytes.size() == 1 && sh_in == 8'h05) begin
                    mo = {1'b1, 6'b0, (busy_left > 0)};
                    if (busy_left > 0) busy_left--;
                end
            end
        end
    end

    always @(negedge spi_sclk) begin
        if (!spi_cs_n) begin
            spi_miso = mo[7];
            mo = {mo[6:0], 1'b0};
        end
    end

    always @(posedge spi_cs_n) begin
        cs_rise_t = $time;
        if (cur_bytes.size() != 0) begin
            if (cur_bytes[0] == 8'h02 || cur_bytes[0] == 8'h20 ||
                cur_bytes[0] == 8'hD8 || cur_bytes[0] == 8'hC7)
                busy_left = cfg_busy;
            foreach (cur_bytes[i]) obs_q.push_back(cur_bytes[i]);
            obs_q.push_back(ENDM);
            cur_bytes.delete();
        end
    end

    // ---------------- data source ----------------
    int dq[$];
    int stall_mode = 0;
    int dcnt = 0;
    bit hs = 0;

    always @(negedge clk) begin
        if (hs) void'(dq.pop_front());
        dcnt++;
        wr_valid = (dq.size() > 0) && (stall_mode == 0 || (dcnt % 3) != 0);
        wr_data  = (dq.size() > 0) ? 8'(dq[0]) : 8'h00;
        #1;
        hs = wr_valid && wr_ready;
    end

    // ---------------- per-clock handshake model ----------------
    bit active = 0;
    int done_cnt = 0;
    bit last_err = 0;
    bit mon_en = 0;

    always @(negedge clk) begin
        #2;
        if (mon_en) begin
            if (done) begin
                active = 0;
                done_cnt++;
                last_err = err;
            end
            check(req_ready == !active, "R9", "req_ready vs idle model", int'(req_ready), int'(!active));
            if (err && !done) check(0, "R8", "err without done", 1, 0);
            if (req_valid && req_ready && !(req_op == 2'd0 && req_len == '0)) active = 1;
        end
    end

    // ---------------- expected stream ----------------
    function automatic int cmd_of(int op);
        case (op)
            0: return 8'h02;
            1: return 8'h20;
            2: return 8'hD8;
            default: return 8'hC7;
        endcase
    endfunction

    function automatic int dbyte(int seed, int j);
        return (seed + 5*j) & 255;
    endfunction

    task automatic build_exp(int op, int addr, int len, int busy, int seed, output bit e_err);
        int a, r, n, j, k;
        bit stop;
        e_err = 0;
        a = addr; r = len; j = 0; stop = 0;
        if (op == 0 && len == 0) return;
        while (!stop) begin
            exp_q.push_back(8'h06); exp_q.push_back(ENDM);
            exp_q.push_back(cmd_of(op));
            if (op != 3) begin
                exp_q.push_back((a >> 16) & 255);
                exp_q.push_back((a >> 8) & 255);
                exp_q.push_back(a & 255);
            end
            if (op == 0) begin
                n = (r < 256 - (a % 256)) ? r : 256 - (a % 256);
                for (int q = 0; q < n; q++) begin
                    exp_q.push_back(dbyte(seed, j));
                    j++;
                end
                a = (a + n) & 24'hFFFFFF;
                r = r - n;
            end
            exp_q.push_back(ENDM);
            k = 0;
            forever begin
                exp_q.push_back(8'h05); exp_q.push_back(8'h00); exp_q.push_back(ENDM);
                k++;
                if (k > busy) break;
                if (k == MAX_POLLS) begin e_err = 1; break; end
            end
            if (e_err || op != 0 || r == 0) stop = 1;
        end
    endtask

    task automatic run_test(int op, int addr, int len, int busy, int stall, int seed, string tag);
        bit e_err;
        int wait_c;
        int mism;
        obs_q.delete();
        exp_q.delete();
        build_exp(op, addr, len, busy, seed, e_err);
        cfg_busy   = busy;
        stall_mode = stall;
        period_bad = 0;
        gap_min    = 1000000;
        done_cnt   = 0;
        if (op == 0) for (int j = 0; j < len; j++) dq.push_back(dbyte(seed, j));
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = 2'(op);
        req_addr  = 24'(addr);
        req_len   = LEN_W'(len);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_c = 0;
        while (done_cnt == 0 && wait_c < 40000) begin
            @(negedge clk);
            wait_c++;
        end
        repeat (30) @(negedge clk);
        check(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
        check(last_err == e_err, "R8", "err flag", int'(last_err), int'(e_err));
        check(obs_q.size() == exp_q.size(), tag, "stream length", obs_q.size(), exp_q.size());
        mism = -1;
        for (int i = 0; i < obs_q.size() && i < exp_q.size(); i++)
            if (mism < 0 && obs_q[i] != exp_q[i]) mism = i;
        if (mism >= 0) check(0, tag, "stream byte mismatch", obs_q[mism], exp_q[mism]);
        else check(1, tag, "stream bytes", 0, 0);
        check(dq.size() == 0, "R10", "data bytes left unconsumed", dq.size(), 0);
        check(period_bad == 0, "R2", "sclk period within byte", int'(period_bad), 0);
        if (exp_q.size() > 0)
            check(gap_min >= GAP_CYC, "R7", "cs_n high gap cycles", gap_min, GAP_CYC);
        else
            check(obs_q.size() == 0, "R11", "no transaction for zero length", obs_q.size(), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(spi_cs_n == 1'b1 && spi_sclk == 1'b0 && req_ready == 1'b1 && done == 1'b0 && err == 1'b0,
              "R1", "outputs during reset", int'({spi_cs_n, spi_sclk, req_ready, done, err}), 5'b10100);
        rst = 1'b0;
        @(negedge clk);
        check(spi_cs_n == 1'b1 && spi_sclk == 1'b0 && req_ready == 1'b1 && done == 1'b0 && err == 1'b0,
              "R1", "outputs after reset", int'({spi_cs_n, spi_sclk, req_ready, done, err}), 5'b10100);
        mon_en = 1;

        run_test(0, 24'h000010,   4,  2, 0, 8'h11, "R3");
        run_test(0, 24'h0001F0,  40,  1, 1, 8'h22, "R5");
        run_test(0, 24'h000300, 256,  0, 0, 8'h33, "R5");
        run_test(0, 24'h00FF80, 300,  0, 1, 8'h44, "R5");
        run_test(0, 24'hFFFFFE,   5,  1, 1, 8'h55, "R5");
        run_test(1, 24'h123456,   0,  3, 0, 8'h00, "R6");
        run_test(2, 24'hABCDEF,   0,  0, 0, 8'h00, "R4");
        run_test(3, 24'h000000,   0,  5, 0, 8'h00, "R4");
        run_test(2, 24'h010000,   0, 20, 0, 8'h00, "R8");
        run_test(0, 24'h000000,   0,  0, 0, 8'h00, "R11");
        run_test(1, 24'h000100,   7,  0, 0, 8'h00, "R6");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule